// File: doc/BRIEF.md
# LIN Slave Transceiver Mode Controller

This block is the digital supervisor that decides which power and communication mode a LIN slave transceiver is in. It works only on digital flags produced elsewhere: two supply comparator outputs, a regulator undervoltage flag, the enable and transmit-data pins from the host microcontroller, a wake indication from the bus wake detector and a flag saying the external reset timer has expired. From these it steps between five modes: unpowered, fail-safe, normal, silent and sleep. It drives the enables for the transmit path, the regulator, the slave termination and the bus receiver.

The host picks a low-power mode by pulling the enable pin low. The level of the transmit-data pin at the end of a short selection window then decides the mode: high selects silent, where the regulator stays on, and low selects sleep, where it is off. When the block leaves a low-power mode because of a bus wake, or enters fail-safe because the supply came up, it reports why. It does this by taking over the receive-data and transmit-data pins and driving them to a code the host can read.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the mode code is 3'b000 (unpowered). In that mode the regulator, termination, transmit path and receiver are all off, no pin is overridden and the reset hold output is high.
- R2: In unpowered, a high `vs_on` moves the mode to fail-safe (3'b001) on the next clock edge. Fail-safe turns the regulator and termination on and keeps the transmit path and receiver off. It drives TXD high and RXD low to report a supply source.
- R3: Fail-safe moves to normal (3'b010) only in a cycle where the synchronized enable is high and `rst_done` is high. It stays in fail-safe while `rst_done` is low. Normal turns the regulator, termination, receiver and transmit path on, with no pin override.
- R4: A falling enable in normal starts a window of SEL_CYC cycles. The mode changes SEL_CYC+3 clock edges after the enable pin falls. A TXD level of 1 at the end of the window gives silent (3'b100) and a level of 0 gives sleep (3'b110). The transmit path is off during the window. Enable returning high inside the window cancels it and leaves the block in normal.
- R5: Silent keeps the regulator on. Sleep turns the regulator off, drives RXD low and asserts the reset hold. Both keep the transmit path and termination off and the receiver on. The regulator undervoltage flag has no effect in sleep.
- R6: A `bus_wake` in silent or sleep moves the block to fail-safe on the next edge and drives TXD low and RXD low (wake source).
- R7: `vcc_uv` in normal or silent moves the block to fail-safe on the next edge with the supply source code (TXD high, RXD low).
- R8: `vs_low` moves the block from any mode to unpowered on the next edge. It takes priority over every other input.
- R9: A synchronized enable high in silent or sleep moves the block to fail-safe with no pin override. Normal follows only once `rst_done` is high.
- R10: The mode code always takes one of the five legal values listed above. A state register holding any other value returns to fail-safe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vs_on | input | 1 | Supply above the switch-on threshold |
| vs_low | input | 1 | Supply below the switch-off threshold |
| vcc_uv | input | 1 | Regulator output undervoltage |
| en_pin | input | 1 | Enable pin from host (asynchronous) |
| txd_pin | input | 1 | Transmit-data pin level (asynchronous) |
| bus_wake | input | 1 | Wake event from the bus wake detector |
| rst_done | input | 1 | External reset timer has expired |
| mode_code | output | 3 | Current mode code |
| tx_en | output | 1 | Transmit path enable |
| reg_en | output | 1 | Regulator enable |
| term_en | output | 1 | Slave termination enable |
| rx_en | output | 1 | Bus receiver enable |
| rxd_force | output | 1 | Block drives the RXD pin |
| rxd_val | output | 1 | Value driven on RXD when forced |
| txd_drive | output | 1 | Block drives the TXD pin as an output |
| txd_val | output | 1 | Value driven on TXD when driven |
| nres_hold | output | 1 | Hold the reset output low |

## Verification
The hardest case to reach is the selection window. The choice between silent and sleep depends on the TXD level at the last cycle of the window, not at the enable edge. An enable that bounces back inside the window must leave normal untouched. The bench gets there by dropping enable and then changing TXD, or raising enable again, a computed number of edges later. It samples exactly at the cycle the mode should change, from the window length plus the synchronizer and edge-detect stages. Each low-power mode is then left by every exit path, including a supply loss at the same time as a wake.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    MODE_UNPWR  = 3'b000,
    MODE_FSAFE  = 3'b001,
    MODE_NORMAL = 3'b010,
    MODE_SILENT = 3'b100,
    MODE_SLEEP  = 3'b110
  } mode_t;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SUPPLY = 2'd1,
    SRC_WAKE   = 2'd2
  } src_t;

  // low-power mode chosen by the TXD level at the end of the window
  function automatic mode_t sel_lowpwr(input logic txd_level);
    return txd_level ? MODE_SILENT : MODE_SLEEP;
  endfunction

  // TXD report level for a fail-safe source: high for supply, low for wake
  function automatic logic src_txd_level(input src_t s);
    return (s == SRC_SUPPLY);
  endfunction

endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_async[i];
        sync_q <= meta_q;
      end
    end
    assign q_sync[i] = sync_q;
  end
endmodule

// File: rtl/lin_sel_window.sv
module lin_sel_window #(
  parameter int SEL_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(SEL_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= CW'(SEL_CYC);
      end
    end else if (cancel || cnt_q == CW'(1)) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active = act_q;
  assign done   = act_q && !cancel && (cnt_q == CW'(1));
endmodule

// File: rtl/lin_mode_outdec.sv
module lin_mode_outdec
  import lin_mode_pkg::*;
(
  input  mode_t mode,
  input  src_t  src,
  input  logic  win_active,
  output logic  tx_en,
  output logic  reg_en,
  output logic  term_en,
  output logic  rx_en,
  output logic  rxd_force,
  output logic  rxd_val,
  output logic  txd_drive,
  output logic  txd_val,
  output logic  nres_hold
);
  always_comb begin
    tx_en     = 1'b0;
    reg_en    = 1'b0;
    term_en   = 1'b0;
    rx_en     = 1'b0;
    rxd_force = 1'b0;
    rxd_val   = 1'b1;
    txd_drive = 1'b0;
    txd_val   = 1'b1;
    nres_hold = 1'b0;
    unique case (mode)
      MODE_UNPWR: nres_hold = 1'b1;
      MODE_FSAFE: begin
        reg_en  = 1'b1;
        term_en = 1'b1;
        if (src != SRC_NONE) begin
          rxd_force = 1'b1;
          rxd_val   = 1'b0;
          txd_drive = 1'b1;
          txd_val   = src_txd_level(src);
        end
      end
      MODE_NORMAL: begin
        reg_en  = 1'b1;
        term_en = 1'b1;
        rx_en   = 1'b1;
        tx_en   = !win_active;
      end
      MODE_SILENT: begin
        reg_en = 1'b1;
        rx_en  = 1'b1;
      end
      MODE_SLEEP: begin
        rx_en     = 1'b1;
        rxd_force = 1'b1;
        rxd_val   = 1'b0;
        nres_hold = 1'b1;
      end
      default: begin
        reg_en  = 1'b1;
        term_en = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int SEL_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vs_on,
  input  logic       vs_low,
  input  logic       vcc_uv,
  input  logic       en_pin,
  input  logic       txd_pin,
  input  logic       bus_wake,
  input  logic       rst_done,
  output logic [2:0] mode_code,
  output logic       tx_en,
  output logic       reg_en,
  output logic       term_en,
  output logic       rx_en,
  output logic       rxd_force,
  output logic       rxd_val,
  output logic       txd_drive,
  output logic       txd_val,
  output logic       nres_hold
);
  logic [1:0] pins_s;
  logic       en_s, txd_s, en_d;
  logic       en_fall, win_start, win_active, win_done;
  mode_t      mode_q, mode_n;
  src_t       src_q, src_n;

  lin_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({txd_pin, en_pin}), .q_sync(pins_s)
  );
  assign en_s  = pins_s[0];
  assign txd_s = pins_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_d <= 1'b0;
    else        en_d <= en_s;
  end
  assign en_fall   = en_d && !en_s;
  assign win_start = (mode_q == MODE_NORMAL) && en_fall;

  lin_sel_window #(.SEL_CYC(SEL_CYC)) u_win (
    .clk(clk), .rst_n(rst_n),
    .start(win_start),
    .cancel(en_s || (mode_q != MODE_NORMAL)),
    .active(win_active), .done(win_done)
  );

  always_comb begin
    mode_n = mode_q;
    src_n  = src_q;
    if (vs_low) begin
      mode_n = MODE_UNPWR;
      src_n  = SRC_NONE;
    end else begin
      unique case (mode_q)
        MODE_UNPWR: if (vs_on) begin
          mode_n = MODE_FSAFE; src_n = SRC_SUPPLY;
        end
        MODE_FSAFE: if (en_s && rst_done) begin
          mode_n = MODE_NORMAL; src_n = SRC_NONE;
        end
        MODE_NORMAL: begin
          if (vcc_uv) begin
            mode_n = MODE_FSAFE; src_n = SRC_SUPPLY;
          end else if (win_done) begin
            mode_n = sel_lowpwr(txd_s);
          end
        end
        MODE_SILENT: begin
          if (bus_wake) begin
            mode_n = MODE_FSAFE; src_n = SRC_WAKE;
          end else if (vcc_uv) begin
            mode_n = MODE_FSAFE; src_n = SRC_SUPPLY;
          end else if (en_s) begin
            mode_n = MODE_FSAFE; src_n = SRC_NONE;
          end
        end
        MODE_SLEEP: begin
          if (bus_wake) begin
            mode_n = MODE_FSAFE; src_n = SRC_WAKE;
          end else if (en_s) begin
            mode_n = MODE_FSAFE; src_n = SRC_NONE;
          end
        end
        default: begin
          mode_n = MODE_FSAFE; src_n = SRC_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_UNPWR;
      src_q  <= SRC_NONE;
    end else begin
      mode_q <= mode_n;
      src_q  <= src_n;
    end
  end

  lin_mode_outdec u_dec (
    .mode(mode_q), .src(src_q), .win_active(win_active),
    .tx_en(tx_en), .reg_en(reg_en), .term_en(term_en), .rx_en(rx_en),
    .rxd_force(rxd_force), .rxd_val(rxd_val),
    .txd_drive(txd_drive), .txd_val(txd_val), .nres_hold(nres_hold)
  );

  assign mode_code = mode_q;
endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk
  import lin_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       vs_low,
  input logic       vcc_uv,
  input logic       bus_wake,
  input logic       rst_done,
  input logic [2:0] mode_code,
  input logic       tx_en,
  input logic       reg_en,
  input logic       term_en,
  input logic       nres_hold,
  input logic       txd_drive,
  input logic       txd_val,
  input logic       win_done
);
  p_unpwr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_UNPWR |-> !reg_en && !tx_en && !term_en && nres_hold);

  p_fs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_FSAFE && !rst_done && !vs_low |=> mode_code == MODE_FSAFE);

  p_window_pick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_done && !vs_low && !vcc_uv |=>
      (mode_code == MODE_SILENT || mode_code == MODE_SLEEP));

  p_sleep_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_SLEEP |-> !reg_en && nres_hold && !tx_en && !term_en);

  p_wake_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_SILENT || mode_code == MODE_SLEEP) && bus_wake && !vs_low
      |=> mode_code == MODE_FSAFE && txd_drive && !txd_val);

  p_uv_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_NORMAL || mode_code == MODE_SILENT) && vcc_uv && !vs_low
      |=> mode_code == MODE_FSAFE);

  p_supply_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vs_low |=> mode_code == MODE_UNPWR);

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code inside {MODE_UNPWR, MODE_FSAFE, MODE_NORMAL, MODE_SILENT, MODE_SLEEP});
endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vs_low(vs_low), .vcc_uv(vcc_uv),
  .bus_wake(bus_wake), .rst_done(rst_done), .mode_code(mode_code),
  .tx_en(tx_en), .reg_en(reg_en), .term_en(term_en), .nres_hold(nres_hold),
  .txd_drive(txd_drive), .txd_val(txd_val), .win_done(win_done)
);

// File: tb/sim_lin_mode_ctrl.sv
module sim_lin_mode_ctrl;
  localparam int PER = 10;
  localparam int SEL = 4;
  localparam int M_UN = 0, M_FS = 1, M_NO = 2, M_SI = 4, M_SL = 6;

  logic clk = 1'b0;
  logic rst_n, vs_on, vs_low, vcc_uv, en_pin, txd_pin, bus_wake, rst_done;
  logic [2:0] mode_code;
  logic tx_en, reg_en, term_en, rx_en, rxd_force, rxd_val, txd_drive, txd_val, nres_hold;
  int n_chk = 0, n_fail = 0;

  always #(PER/2) clk = ~clk;

  lin_mode_ctrl #(.SEL_CYC(SEL)) u0 (
    .clk(clk), .rst_n(rst_n), .vs_on(vs_on), .vs_low(vs_low), .vcc_uv(vcc_uv),
    .en_pin(en_pin), .txd_pin(txd_pin), .bus_wake(bus_wake), .rst_done(rst_done),
    .mode_code(mode_code), .tx_en(tx_en), .reg_en(reg_en), .term_en(term_en),
    .rx_en(rx_en), .rxd_force(rxd_force), .rxd_val(rxd_val),
    .txd_drive(txd_drive), .txd_val(txd_val), .nres_hold(nres_hold)
  );

  // expected {reg,term,tx,rx,rxf,rxv,txf,txv,hold}; src 0 none, 1 supply, 2 wake
  function automatic logic [8:0] exp_out(input int m, input int s);
    case (m)
      M_UN: return 9'b0000_0101_1;
      M_FS: return (s == 0) ? 9'b1100_0101_0 :
                   (s == 1) ? 9'b1100_1011_0 : 9'b1100_1010_0;
      M_NO: return 9'b1111_0101_0;
      M_SI: return 9'b1001_0101_0;
      default: return 9'b0001_1001_1;
    endcase
  endfunction

  function automatic int is_legal(input logic [2:0] c);
    return (c == 3'd0 || c == 3'd1 || c == 3'd2 || c == 3'd4 || c == 3'd6) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int m, input int s);
    chk(req, int'(mode_code), m);
    chk(req, int'({reg_en, term_en, tx_en, rx_en, rxd_force, rxd_val,
                   txd_drive, txd_val, nres_hold}), int'(exp_out(m, s)));
    chk("R10", is_legal(mode_code), 1);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_normal();
    en_pin = 1'b1; rst_done = 1'b1;
    step(3);
    chk_state("R3", M_NO, 0);
  endtask

  // EN falls with a TXD level; mode changes SEL+3 edges after the pin edge
  task automatic enter_low(input logic lvl);
    txd_pin = lvl; en_pin = 1'b0; rst_done = 1'b0;
    step(2 + SEL);
    chk("R4", int'(mode_code), M_NO);
    chk("R4", int'(tx_en), 0);
    step(1);
    chk_state("R5", lvl ? M_SI : M_SL, 0);
  endtask

  initial begin
    #(PER * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vs_on = 1'b0; vs_low = 1'b0; vcc_uv = 1'b0; en_pin = 1'b0;
    txd_pin = 1'b1; bus_wake = 1'b0; rst_done = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk_state("R1", M_UN, 0);

    vs_on = 1'b1; step(1); vs_on = 1'b0;
    chk_state("R2", M_FS, 1);

    en_pin = 1'b1; step(6);
    chk_state("R3", M_FS, 1);
    rst_done = 1'b1; step(1);
    chk_state("R3", M_NO, 0);

    for (int t = 0; t < 2; t++) begin
      for (int ex = 0; ex < 3; ex++) begin
        enter_low(t[0]);
        if (ex == 0) begin
          bus_wake = 1'b1; step(1); bus_wake = 1'b0;
          chk_state("R6", M_FS, 2);
        end else if (ex == 1) begin
          vcc_uv = 1'b1;
          if (t == 1) begin
            step(1); vcc_uv = 1'b0;
            chk_state("R7", M_FS, 1);
          end else begin
            step(2); vcc_uv = 1'b0;
            chk_state("R5", M_SL, 0);
            bus_wake = 1'b1; step(1); bus_wake = 1'b0;
            chk_state("R6", M_FS, 2);
          end
        end else begin
          en_pin = 1'b1; step(3);
          chk_state("R9", M_FS, 0);
          step(4);
          chk_state("R9", M_FS, 0);
        end
        go_normal();
      end
    end

    vcc_uv = 1'b1; step(1); vcc_uv = 1'b0;
    chk_state("R7", M_FS, 1);
    go_normal();

    txd_pin = 1'b1; en_pin = 1'b0; step(4);
    en_pin = 1'b1; step(SEL + 4);
    chk_state("R4", M_NO, 0);

    txd_pin = 1'b1; en_pin = 1'b0; rst_done = 1'b0; step(3);
    txd_pin = 1'b0; step(SEL);
    chk_state("R4", M_SL, 0);
    en_pin = 1'b1; step(3);
    chk_state("R9", M_FS, 0);
    go_normal();

    for (int m = 0; m < 4; m++) begin
      if (m == 1) enter_low(1'b1);
      if (m == 2) enter_low(1'b0);
      if (m == 3) begin
        vcc_uv = 1'b1; step(1); vcc_uv = 1'b0;
      end
      vs_low = 1'b1; bus_wake = 1'b1; step(1);
      vs_low = 1'b0; bus_wake = 1'b0;
      chk_state("R8", M_UN, 0);
      vs_on = 1'b1; step(1); vs_on = 1'b0;
      chk_state("R2", M_FS, 1);
      go_normal();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule